// File: doc/BRIEF.md
# Address Range Watchpoint Unit

This block watches the stream of memory accesses that an arbiter grants and raises an interrupt when an access lands where software asked to be told about it. It holds four independent watchpoints. Each one is programmed with an inclusive address window, a mask of operation types (read, write) and a mask of requesting clients. A watchpoint hits only when all three conditions agree for the same valid access.

On a hit the watchpoint sets its pending bit and records the details of the access: the address, the operation, the client that caused the first hit, the access size, and the set of clients that hit while the record was held. The record is frozen at the first hit and is re-armed by a write to that watchpoint's acknowledge location. Pending bits are cleared separately, one bit per watchpoint, through a global acknowledge register. A global mask selects which pending bits drive the level-sensitive interrupt line. When several are pending, software services them lowest index first.

Software reaches all state through a single-cycle register port. Writes take effect at the clock edge. Reads are combinational from the addressed register.

Top module: `addr_watch_unit`

## Requirements
- R1: After reset every configuration register, capture register, the mask and the pending bits read 0, and `irq` is low.
- R2: Watchpoint i occupies register addresses 16*i+k. The offsets are k=0 first address, k=1 last address, k=2 operation mask (2 bits), k=3 client mask (16 bits), k=4 captured client set, k=5 captured address, k=6 captured operation, k=7 first client, k=8 captured size, and k=9 acknowledge (write only). Global registers are 0x40 interrupt mask (4 bits), 0x41 pending bits, 0x42 masked pending bits and 0x43 interrupt acknowledge (write only). Writable fields read back what was written, truncated to their width.
- R3: An access is inside the window of a watchpoint when first <= address <= last. Both ends are included. An address one below first or one above last does not hit.
- R4: `mon_op` is one-hot: bit 0 is a read and bit 1 is a write. The access hits only if it shares a set bit with the watchpoint's operation mask.
- R5: The access hits only if bit `mon_client` of the watchpoint's client mask is set.
- R6: A cycle with `mon_valid` low changes no pending bit and no capture register, whatever the other monitor inputs carry.
- R7: The first hit of an armed watchpoint records the address, operation, client id and size. Later hits leave these unchanged but OR the client's one-hot bit into the captured client set.
- R8: A write of any data to offset 9 re-arms the watchpoint. It clears the captured client set, so that the next hit records afresh. It does not clear the pending bit.
- R9: A hit sets pending bit i regardless of the mask. Register 0x42 reads pending AND mask. `irq` is high while any masked pending bit is set and stays high until that bit is cleared or masked.
- R10: Writing 0x43 with bit i set clears pending bit i and leaves the other bits alone. A hit in the same cycle keeps its bit set.
- R11: One access can hit several watchpoints at once, and each of them records it independently.
- R12: Reads of acknowledge locations, unused offsets 10 to 15 and global addresses above 0x43 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| mon_valid | input | 1 | Monitored access present this cycle |
| mon_addr | input | 32 | Access address |
| mon_client | input | 4 | Requesting client id |
| mon_op | input | 2 | One-hot operation, bit 0 read, bit 1 write |
| mon_size | input | 3 | Access size code |
| irq | output | 1 | Level interrupt, OR of masked pending bits |

## Verification
Directed accesses probe each window at first-1, first, last and last+1. Matching addresses are paired with the wrong operation or with a client outside the mask. Together these show that all three match terms are each required. Repeated hits from different clients before and after an acknowledge separate the frozen fields from the accumulating client set. A clear and a hit in the same cycle checks which one wins. Overlapping windows with partial masks show that each watchpoint pends independently and that the mask gates only the interrupt. A long random run with small address windows mixes programming, acknowledges and accesses, so the order of these operations is exercised in many combinations.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int NUM_WP   = 4;
  localparam int OFS_BITS = 4;

  typedef enum logic [OFS_BITS-1:0] {
    OFS_FIRST   = 4'd0,
    OFS_LAST    = 4'd1,
    OFS_OPMASK  = 4'd2,
    OFS_CLMASK  = 4'd3,
    OFS_CAP_CL  = 4'd4,
    OFS_CAP_AD  = 4'd5,
    OFS_CAP_OP  = 4'd6,
    OFS_CAP_1ST = 4'd7,
    OFS_CAP_SZ  = 4'd8,
    OFS_ACK     = 4'd9
  } wp_ofs_e;

  typedef enum logic [OFS_BITS-1:0] {
    GLB_MASK = 4'd0,
    GLB_RAW  = 4'd1,
    GLB_MST  = 4'd2,
    GLB_IACK = 4'd3
  } glb_ofs_e;

  localparam int OP_W = 2;
endpackage

// File: rtl/wp_slot.sv
module wp_slot
  import wp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int CLIENTS = 16,
  parameter int SIZE_W  = 3,
  localparam int CID_W  = $clog2(CLIENTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [OFS_BITS-1:0] wr_ofs,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [OFS_BITS-1:0] rd_ofs,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                mon_valid,
  input  logic [ADDR_W-1:0]   mon_addr,
  input  logic [CID_W-1:0]    mon_client,
  input  logic [OP_W-1:0]     mon_op,
  input  logic [SIZE_W-1:0]   mon_size,
  output logic                hit,
  output logic                held,
  output logic [ADDR_W-1:0]   cap_addr
);
  logic [ADDR_W-1:0]  first_q, first_d, last_q, last_d;
  logic [OP_W-1:0]    opm_q, opm_d;
  logic [CLIENTS-1:0] clm_q, clm_d;
  logic               held_q, held_d;
  logic [ADDR_W-1:0]  cad_q, cad_d;
  logic [OP_W-1:0]    cop_q, cop_d;
  logic [CID_W-1:0]   c1st_q, c1st_d;
  logic [SIZE_W-1:0]  csz_q, csz_d;
  logic [CLIENTS-1:0] ccl_q, ccl_d;
  logic               ack, in_win, op_ok, cl_ok, take;
  logic [CLIENTS-1:0] cl_onehot;

  always_comb begin
    in_win    = (mon_addr >= first_q) && (mon_addr <= last_q);
    op_ok     = |(mon_op & opm_q);
    cl_ok     = clm_q[mon_client];
    hit       = mon_valid && in_win && op_ok && cl_ok;
    ack       = wr_en && (wr_ofs == OFS_ACK);
    take      = hit && (!held_q || ack);
    cl_onehot = CLIENTS'(1) << mon_client;
  end

  always_comb begin
    first_d = first_q;
    last_d  = last_q;
    opm_d   = opm_q;
    clm_d   = clm_q;
    if (wr_en) begin
      case (wr_ofs)
        OFS_FIRST:  first_d = wdata[ADDR_W-1:0];
        OFS_LAST:   last_d  = wdata[ADDR_W-1:0];
        OFS_OPMASK: opm_d   = wdata[OP_W-1:0];
        OFS_CLMASK: clm_d   = wdata[CLIENTS-1:0];
        default: ;
      endcase
    end
    held_d = held_q;
    ccl_d  = ccl_q;
    cad_d  = cad_q;
    cop_d  = cop_q;
    c1st_d = c1st_q;
    csz_d  = csz_q;
    if (ack) begin
      held_d = 1'b0;
      ccl_d  = '0;
    end
    if (hit) begin
      held_d = 1'b1;
      ccl_d  = ccl_d | cl_onehot;
    end
    if (take) begin
      cad_d  = mon_addr;
      cop_d  = mon_op;
      c1st_d = mon_client;
      csz_d  = mon_size;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      last_q  <= '0;
      opm_q   <= '0;
      clm_q   <= '0;
      held_q  <= 1'b0;
      ccl_q   <= '0;
      cad_q   <= '0;
      cop_q   <= '0;
      c1st_q  <= '0;
      csz_q   <= '0;
    end else begin
      first_q <= first_d;
      last_q  <= last_d;
      opm_q   <= opm_d;
      clm_q   <= clm_d;
      held_q  <= held_d;
      ccl_q   <= ccl_d;
      cad_q   <= cad_d;
      cop_q   <= cop_d;
      c1st_q  <= c1st_d;
      csz_q   <= csz_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_ofs)
      OFS_FIRST:   rd_data = DATA_W'(first_q);
      OFS_LAST:    rd_data = DATA_W'(last_q);
      OFS_OPMASK:  rd_data = DATA_W'(opm_q);
      OFS_CLMASK:  rd_data = DATA_W'(clm_q);
      OFS_CAP_CL:  rd_data = DATA_W'(ccl_q);
      OFS_CAP_AD:  rd_data = DATA_W'(cad_q);
      OFS_CAP_OP:  rd_data = DATA_W'(cop_q);
      OFS_CAP_1ST: rd_data = DATA_W'(c1st_q);
      OFS_CAP_SZ:  rd_data = DATA_W'(csz_q);
      default:     rd_data = '0;
    endcase
  end

  assign held     = held_q;
  assign cap_addr = cad_q;
endmodule

// File: rtl/wp_irq_ctrl.sv
module wp_irq_ctrl #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic         mask_we,
  input  logic         iack_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mask,
  output logic [N-1:0] pend,
  output logic         irq
);
  logic [N-1:0] mask_q, mask_d, pend_q, pend_d, clr;

  always_comb begin
    clr    = iack_we ? wdata : '0;
    pend_d = (pend_q & ~clr) | hit;
    mask_d = mask_we ? wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
    end else begin
      mask_q <= mask_d;
      pend_q <= pend_d;
    end
  end

  assign mask = mask_q;
  assign pend = pend_q;
  assign irq  = |(pend_q & mask_q);
endmodule

// File: rtl/addr_watch_unit.sv
module addr_watch_unit
  import wp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int CLIENTS = 16,
  parameter int SIZE_W  = 3,
  localparam int CID_W  = $clog2(CLIENTS),
  localparam int SEL_W  = $clog2(NUM_WP),
  localparam int REG_AW = 1 + SEL_W + OFS_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              mon_valid,
  input  logic [ADDR_W-1:0] mon_addr,
  input  logic [CID_W-1:0]  mon_client,
  input  logic [OP_W-1:0]   mon_op,
  input  logic [SIZE_W-1:0] mon_size,
  output logic              irq
);
  logic                rst_s0, rst_sync_n;
  logic                is_glb;
  logic [SEL_W-1:0]    sel;
  logic [OFS_BITS-1:0] ofs;
  logic [NUM_WP-1:0]   slot_we, hit, held, mask, pend;
  logic [DATA_W-1:0]   slot_rd [NUM_WP];
  logic [NUM_WP*ADDR_W-1:0] cap_addr_flat;
  logic                mask_we, iack_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s0     <= 1'b1;
      rst_sync_n <= rst_s0;
    end
  end

  always_comb begin
    is_glb  = reg_addr[REG_AW-1];
    sel     = reg_addr[OFS_BITS +: SEL_W];
    ofs     = reg_addr[OFS_BITS-1:0];
    mask_we = reg_wr && is_glb && (sel == '0) && (ofs == GLB_MASK);
    iack_we = reg_wr && is_glb && (sel == '0) && (ofs == GLB_IACK);
    for (int i = 0; i < NUM_WP; i++)
      slot_we[i] = reg_wr && !is_glb && (sel == SEL_W'(i));
  end

  for (genvar g = 0; g < NUM_WP; g++) begin : g_slot
    wp_slot #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLIENTS(CLIENTS), .SIZE_W(SIZE_W)
    ) i_slot (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .wr_en      (slot_we[g]),
      .wr_ofs     (ofs),
      .wdata      (reg_wdata),
      .rd_ofs     (ofs),
      .rd_data    (slot_rd[g]),
      .mon_valid  (mon_valid),
      .mon_addr   (mon_addr),
      .mon_client (mon_client),
      .mon_op     (mon_op),
      .mon_size   (mon_size),
      .hit        (hit[g]),
      .held       (held[g]),
      .cap_addr   (cap_addr_flat[g*ADDR_W +: ADDR_W])
    );
  end

  wp_irq_ctrl #(.N(NUM_WP)) i_irq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .hit     (hit),
    .mask_we (mask_we),
    .iack_we (iack_we),
    .wdata   (reg_wdata[NUM_WP-1:0]),
    .mask    (mask),
    .pend    (pend),
    .irq     (irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (!is_glb) begin
      reg_rdata = slot_rd[sel];
    end else if (sel == '0) begin
      case (ofs)
        GLB_MASK: reg_rdata = DATA_W'(mask);
        GLB_RAW:  reg_rdata = DATA_W'(pend);
        GLB_MST:  reg_rdata = DATA_W'(pend & mask);
        default:  reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/addr_watch_checker.sv
module addr_watch_checker
  import wp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 7
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_wr,
  input logic [REG_AW-1:0]        reg_addr,
  input logic [NUM_WP-1:0]        reg_wbits,
  input logic                     mon_valid,
  input logic                     irq,
  input logic [NUM_WP-1:0]        hit,
  input logic [NUM_WP-1:0]        pend,
  input logic [NUM_WP-1:0]        held,
  input logic [NUM_WP*ADDR_W-1:0] cap_addr
);
  localparam logic [REG_AW-1:0] IACK_A = REG_AW'((NUM_WP << OFS_BITS) + 3);

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reg_wr) |=> irq); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon_valid && !reg_wr) |=> $stable(pend)); // R6

  for (genvar g = 0; g < NUM_WP; g++) begin : g_chk
    localparam logic [REG_AW-1:0] ACK_A = REG_AW'((g << OFS_BITS) + 9);

    AST_HIT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] |=> pend[g]); // R9

    AST_IACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == IACK_A && reg_wbits[g] && !hit[g]) |=> !pend[g]); // R10

    AST_CAPTURE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (held[g] && !(reg_wr && reg_addr == ACK_A))
        |=> $stable(cap_addr[g*ADDR_W +: ADDR_W])); // R7
  end
endmodule

bind addr_watch_unit addr_watch_checker #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wbits (reg_wdata[wp_pkg::NUM_WP-1:0]),
  .mon_valid (mon_valid),
  .irq       (irq),
  .hit       (hit),
  .pend      (pend),
  .held      (held),
  .cap_addr  (cap_addr_flat)
);

// File: tb/test_addr_watch_unit.sv
`timescale 1ns/10ps
module test_addr_watch_unit;
  logic        clk, rst_n, reg_wr, mon_valid, irq;
  logic [6:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, mon_addr;
  logic [3:0]  mon_client;
  logic [1:0]  mon_op;
  logic [2:0]  mon_size;

  int n_cmp = 0, n_bad = 0;

  addr_watch_unit i_addr_watch_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mon_valid(mon_valid),
    .mon_addr(mon_addr), .mon_client(mon_client), .mon_op(mon_op),
    .mon_size(mon_size), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // expected state
  logic [31:0] m_first[4], m_last[4], m_caddr[4];
  logic [1:0]  m_opm[4], m_cop[4];
  logic [15:0] m_clm[4], m_ccl[4];
  logic [3:0]  m_c1st[4], m_mask, m_pend;
  logic [2:0]  m_csz[4];
  logic        m_held[4];

  function automatic logic f_hit(int i, logic v, logic [31:0] a, logic [3:0] c, logic [1:0] o);
    return v && a >= m_first[i] && a <= m_last[i] && (o & m_opm[i]) != 0 && m_clm[i][c];
  endfunction

  function automatic logic [31:0] f_exp(logic [6:0] a);
    int i = a[5:4];
    if (a[6]) begin
      if (a[5:4] != 0) return 0;
      case (a[3:0])
        0: return 32'(m_mask);
        1: return 32'(m_pend);
        2: return 32'(m_pend & m_mask);
        default: return 0;
      endcase
    end
    case (a[3:0])
      0: return m_first[i];
      1: return m_last[i];
      2: return 32'(m_opm[i]);
      3: return 32'(m_clm[i]);
      4: return 32'(m_ccl[i]);
      5: return m_caddr[i];
      6: return 32'(m_cop[i]);
      7: return 32'(m_c1st[i]);
      8: return 32'(m_csz[i]);
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.1;
    d = reg_rdata;
  endtask

  task automatic check_all(string req);
    logic [31:0] d;
    for (int i = 0; i < 4; i++)
      for (int k = 0; k < 10; k++) begin
        rd(7'(i*16 + k), d);
        chk(req, $sformatf("reg %02h", i*16+k), d, f_exp(7'(i*16+k)));
      end
    for (int k = 0; k < 5; k++) begin
      rd(7'(64 + k), d);
      chk(req, $sformatf("reg %02h", 64+k), d, f_exp(7'(64+k)));
    end
    rd(7'h7f, d);
    chk(req, "reg 7f", d, 0);
    chk(req, "irq", 32'(irq), 32'(|(m_pend & m_mask)));
  endtask

  // one clock cycle with optional write and optional access
  task automatic cyc(logic w, logic [6:0] wa, logic [31:0] wd,
                     logic v, logic [31:0] a, logic [3:0] c, logic [1:0] o, logic [2:0] s);
    logic [3:0] h;
    @(negedge clk);
    reg_wr = w; reg_addr = wa; reg_wdata = wd;
    mon_valid = v; mon_addr = a; mon_client = c; mon_op = o; mon_size = s;
    for (int i = 0; i < 4; i++) h[i] = f_hit(i, v, a, c, o);
    @(posedge clk);
    #1;
    for (int i = 0; i < 4; i++) begin
      logic ack, take;
      ack  = w && wa == 7'(i*16 + 9);
      take = h[i] && (!m_held[i] || ack);
      if (ack) begin m_held[i] = 0; m_ccl[i] = 0; end
      if (h[i]) begin m_held[i] = 1; m_ccl[i] |= 16'(1) << c; end
      if (take) begin m_caddr[i] = a; m_cop[i] = o; m_c1st[i] = c; m_csz[i] = s; end
      if (w && !wa[6] && wa[5:4] == 2'(i))
        case (wa[3:0])
          0: m_first[i] = wd;
          1: m_last[i]  = wd;
          2: m_opm[i]   = wd[1:0];
          3: m_clm[i]   = wd[15:0];
          default: ;
        endcase
    end
    m_pend = (m_pend & ~((w && wa == 7'h43) ? wd[3:0] : 4'h0)) | h;
    if (w && wa == 7'h40) m_mask = wd[3:0];
    reg_wr = 0; mon_valid = 0;
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    cyc(1, a, d, 0, 0, 0, 0, 0);
  endtask

  task automatic acc(logic [31:0] a, logic [3:0] c, logic [1:0] o, logic [2:0] s);
    cyc(0, 0, 0, 1, a, c, o, s);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    rst_n = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0; mon_valid = 0;
    mon_addr = 0; mon_client = 0; mon_op = 0; mon_size = 0;
    for (int i = 0; i < 4; i++) begin
      m_first[i] = 0; m_last[i] = 0; m_opm[i] = 0; m_clm[i] = 0; m_ccl[i] = 0;
      m_caddr[i] = 0; m_cop[i] = 0; m_c1st[i] = 0; m_csz[i] = 0; m_held[i] = 0;
    end
    m_mask = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check_all("R1");

    // R2: programming and readback
    wr(7'h00, 32'h0000_1000); wr(7'h01, 32'h0000_10ff);
    wr(7'h02, 32'hffff_fff1); wr(7'h03, 32'hffff_0008);
    wr(7'h40, 32'hffff_fff1);
    check_all("R2");
    rd(7'h02, d); chk("R2", "opmask truncated", d, 32'h1);

    // R3 window edges
    acc(32'h0fff, 3, 2'b01, 2);
    acc(32'h1100, 3, 2'b01, 2);
    rd(7'h41, d); chk("R3", "no hit outside window", d, 0);
    // R4 wrong op, R5 wrong client, R6 valid low
    acc(32'h1000, 3, 2'b10, 2);
    rd(7'h41, d); chk("R4", "write vs read-only mask", d, 0);
    acc(32'h1000, 4, 2'b01, 2);
    rd(7'h41, d); chk("R5", "client outside mask", d, 0);
    cyc(0, 0, 0, 0, 32'h1000, 3, 2'b01, 2);
    rd(7'h41, d); chk("R6", "valid low", d, 0);
    chk("R6", "irq idle", 32'(irq), 0);
    acc(32'h1000, 3, 2'b01, 5);
    rd(7'h41, d); chk("R3", "first address hits", d, 1);
    chk("R9", "irq raised", 32'(irq), 1);
    check_all("R7");
    // R7: later hit from another client
    wr(7'h03, 32'h0000_0088);
    acc(32'h10ff, 7, 2'b01, 1);
    rd(7'h05, d); chk("R7", "address frozen", d, 32'h1000);
    rd(7'h04, d); chk("R7", "client set accumulates", d, 32'h88);
    check_all("R7");
    // R8: ack rearms, pending stays
    wr(7'h09, 32'h0);
    rd(7'h41, d); chk("R8", "pending kept after ack", d, 1);
    rd(7'h04, d); chk("R8", "client set cleared", d, 0);
    acc(32'h1080, 7, 2'b01, 3);
    rd(7'h05, d); chk("R8", "new capture address", d, 32'h1080);
    check_all("R8");
    // R10: clear, then clear with simultaneous hit
    wr(7'h43, 32'h1);
    chk("R10", "irq cleared", 32'(irq), 0);
    cyc(1, 7'h43, 32'h1, 1, 32'h1001, 3, 2'b01, 0);
    rd(7'h41, d); chk("R10", "hit wins over clear", d, 1);
    check_all("R10");
    // R11 + R9: overlapping wp1 unmasked
    wr(7'h10, 32'h1000); wr(7'h11, 32'h1000); wr(7'h12, 32'h3); wr(7'h13, 32'hffff);
    wr(7'h43, 32'hf);
    acc(32'h1000, 3, 2'b01, 6);
    rd(7'h41, d); chk("R11", "both pend", d, 32'h3);
    rd(7'h42, d); chk("R9", "masked view", d, 32'h1);
    wr(7'h43, 32'h1);
    chk("R9", "masked-off pend leaves irq low", 32'(irq), 0);
    rd(7'h41, d); chk("R10", "other bit kept", d, 32'h2);
    check_all("R11");
    rd(7'h19, d); chk("R12", "ack reads zero", d, 0);

    // random phase over small windows
    for (int n = 0; n < 400; n++) begin
      int r = $urandom_range(0, 99);
      int i = $urandom_range(0, 3);
      if (r < 25) begin
        int k = $urandom_range(0, 3);
        logic [31:0] v = (k < 2) ? 32'($urandom_range(0, 63)) : $urandom;
        wr(7'(i*16 + k), v);
      end else if (r < 33) wr(7'(i*16 + 9), $urandom);
      else if (r < 41) wr(7'h43, $urandom);
      else if (r < 47) wr(7'h40, $urandom);
      else if (r < 52) cyc(0, 0, 0, 0, 32'($urandom_range(0, 63)), 4'($urandom), 2'b01, 0);
      else acc(32'($urandom_range(0, 63)), 4'($urandom), $urandom_range(0, 1) ? 2'b01 : 2'b10,
               3'($urandom));
      check_all("R3/R4/R5/R7/R8/R9/R10/R11 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule